// File: doc/BRIEF.md
# Two-Channel PWM Action Qualifier with Continuous Force

This block turns time-base events into two PWM pin levels. A time-base counter elsewhere reports four events as strobes: the counter reached zero, it reached the period, and it matched compare A or compare B while counting up. Each channel holds an action word with one 2-bit field per event. The field says whether that event leaves the pin alone, drives it low, drives it high or toggles it. The pins change only on cycles where the tick enable is high.

Software can also pin either output low or high with a continuous force code. A reload mode in a setup register selects when a newly written force code becomes active. It can load at once, or it can wait in a shadow copy until a zero event, a period event, or either of the two. Once a force is active it overrides every event action on its channel until it is cleared.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both pins are low, both action words are zero, the reload mode is 00 and both force codes (shadow and active) are 00. A tick with all four events then leaves both pins low.
- R2: Every action field uses one encoding: 00 keeps the pin, 01 drives it low, 10 drives it high and 11 inverts it. The pin changes at the clock edge on which a tick carrying the event is sampled.
- R3: In each action word the zero event uses bits 1:0, the period event bits 3:2, the compare-A-up event bits 5:4 and the compare-B-up event bits 9:8. Address 0 writes the word for pin A and address 1 the word for pin B.
- R4: When tick is low, event strobes have no effect on either pin.
- R5: When several events arrive on one tick, the priority rises in the order zero, period, compare A, compare B. The highest present event alone decides the result, even when its field is 00.
- R6: The force code is written at address 3, bits 1:0 for pin A and bits 3:2 for pin B. An active code of 01 holds the pin low on every tick, and 10 holds it high, whatever the events. Codes 00 and 11 leave the pin to the events.
- R7: With reload mode 11 (bits 7:6 of address 2), a force write becomes active at once. It governs the pin from the next tick, and the pin does not move before that tick.
- R8: With reload mode 00, 01 or 10, a force write goes to a shadow copy. The shadow copy becomes active on a tick carrying a zero event (00), a period event (01) or either one (10). Other ticks leave the active force unchanged.
- R9: On the tick that moves the shadow force into the active force, the pin still follows the old force or the events. The new force governs from the following tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base tick enable; events count only with it |
| ev_zero | input | 1 | Counter equals zero |
| ev_period | input | 1 | Counter equals period |
| ev_cmpa_up | input | 1 | Counter equals compare A while counting up |
| ev_cmpb_up | input | 1 | Counter equals compare B while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 act A, 1 act B, 2 setup, 3 force) |
| wr_data | input | 16 | Register write data |
| out_a | output | 1 | Pin level, channel A |
| out_b | output | 1 | Pin level, channel B |

## Verification
The assertions assume the event strobes and writes are plain synchronous levels, and that only the tick enable moves the pins. They also assume the upstream time base raises the zero and period events on ticks only. The stimulus drives every input on the falling edge and holds each one for a single cycle. It never issues a write on the same cycle as a tick, so the order of a force load and a force write never becomes ambiguous.

// File: rtl/aq_pkg.sv
package aq_pkg;
  localparam int NUM_CH  = 2;
  localparam int NUM_EV  = 4;
  localparam int CODE_W  = 2;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 2;
  localparam int FORCE_W = NUM_CH * CODE_W;
  localparam int RLD_LSB = 6;

  localparam logic [ADDR_W-1:0] ADR_SETUP = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_FORCE = 2'd3;

  typedef enum logic [CODE_W-1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_INVERT = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ON_ZERO   = 2'b00,
    RLD_ON_PERIOD = 2'b01,
    RLD_ON_EITHER = 2'b10,
    RLD_AT_ONCE   = 2'b11
  } rld_e;

  // Bit position of an event's field inside an action word.
  function automatic int field_lsb(input int ev);
    return (ev == 3) ? 8 : 2 * ev;
  endfunction

  // Next pin level for an action code.
  function automatic logic apply_act(input act_e code, input logic cur);
    case (code)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_INVERT: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // Only 01 and 10 force the pin.
  function automatic logic is_forcing(input logic [CODE_W-1:0] f);
    return (f == 2'b01) || (f == 2'b10);
  endfunction
endpackage

// File: rtl/aq_regs.sv
module aq_regs
  import aq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           tick,
  input  logic                           ev_zero,
  input  logic                           ev_period,
  output logic [NUM_CH-1:0][DATA_W-1:0]  act_words,
  output rld_e                           rld_mode,
  output logic [FORCE_W-1:0]             force_now
);
  logic [FORCE_W-1:0] force_shadow;
  logic               wr_force;
  logic               load_ev;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        act_words[ch] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(ch)))
        act_words[ch] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rld_mode <= RLD_ON_ZERO;
    else if (wr_en && (wr_addr == ADR_SETUP))
      rld_mode <= rld_e'(wr_data[RLD_LSB +: 2]);
  end

  assign wr_force = wr_en && (wr_addr == ADR_FORCE);

  always_comb begin
    case (rld_mode)
      RLD_ON_ZERO:   load_ev = tick && ev_zero;
      RLD_ON_PERIOD: load_ev = tick && ev_period;
      RLD_ON_EITHER: load_ev = tick && (ev_zero || ev_period);
      default:       load_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_shadow <= '0;
      force_now    <= '0;
    end else begin
      if (wr_force)
        force_shadow <= wr_data[FORCE_W-1:0];
      if (wr_force && (rld_mode == RLD_AT_ONCE))
        force_now <= wr_data[FORCE_W-1:0];
      else if (load_ev)
        force_now <= force_shadow;
    end
  end
endmodule

// File: rtl/aq_evsel.sv
module aq_evsel
  import aq_pkg::*;
(
  input  logic [NUM_EV-1:0] ev_vec,
  input  logic [DATA_W-1:0] act_word,
  output logic              sel_valid,
  output act_e              sel_code
);
  // Ascending scan: a later (higher-priority) event overwrites.
  always_comb begin
    sel_valid = 1'b0;
    sel_code  = ACT_KEEP;
    for (int ev = 0; ev < NUM_EV; ev++) begin
      if (ev_vec[ev]) begin
        sel_valid = 1'b1;
        sel_code  = act_e'(act_word[field_lsb(ev) +: CODE_W]);
      end
    end
  end
endmodule

// File: rtl/aq_chan.sv
module aq_chan
  import aq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sel_valid,
  input  act_e              sel_code,
  input  logic [CODE_W-1:0] force_code,
  output logic              pin
);
  logic pin_next;

  always_comb begin
    pin_next = pin;
    if (tick) begin
      if (is_forcing(force_code))
        pin_next = (force_code == 2'b10);
      else if (sel_valid)
        pin_next = apply_act(sel_code, pin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_next;
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import aq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ev_zero,
  input  logic              ev_period,
  input  logic              ev_cmpa_up,
  input  logic              ev_cmpb_up,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_a,
  output logic              out_b
);
  logic [NUM_EV-1:0]             ev_vec;
  logic [NUM_CH-1:0][DATA_W-1:0] act_words;
  rld_e                          rld_mode;
  logic [FORCE_W-1:0]            force_now;
  logic [NUM_CH-1:0]             sel_valid;
  logic [NUM_CH-1:0][CODE_W-1:0] sel_code;
  logic [NUM_CH-1:0]             pins;

  assign ev_vec = {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero};

  aq_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tick      (tick),
    .ev_zero   (ev_zero),
    .ev_period (ev_period),
    .act_words (act_words),
    .rld_mode  (rld_mode),
    .force_now (force_now)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    act_e code_e;

    aq_evsel sel_i (
      .ev_vec    (ev_vec),
      .act_word  (act_words[ch]),
      .sel_valid (sel_valid[ch]),
      .sel_code  (code_e)
    );

    assign sel_code[ch] = code_e;

    aq_chan chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .sel_valid  (sel_valid[ch]),
      .sel_code   (code_e),
      .force_code (force_now[ch*CODE_W +: CODE_W]),
      .pin        (pins[ch])
    );
  end

  assign out_a = pins[0];
  assign out_b = pins[1];
endmodule

// File: rtl/aq_checker.sv
module aq_checker
  import aq_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [DATA_W-1:0]             wr_data,
  input logic [1:0]                    rld_mode,
  input logic [FORCE_W-1:0]            force_now,
  input logic [NUM_CH-1:0]             sel_valid,
  input logic [NUM_CH-1:0][CODE_W-1:0] sel_code,
  input logic [NUM_CH-1:0]             pins
);
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pins));

  a_r6_force_low_a: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_now[1:0] == 2'b01) |=> !pins[0]);

  a_r6_force_high_a: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_now[1:0] == 2'b10) |=> pins[0]);

  a_r6_force_low_b: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_now[3:2] == 2'b01) |=> !pins[1]);

  a_r6_force_high_b: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_now[3:2] == 2'b10) |=> pins[1]);

  a_r7_at_once_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_FORCE && rld_mode == 2'b11)
      |=> force_now == $past(wr_data[FORCE_W-1:0]));

  a_r8_force_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick) |=> $stable(force_now));

  a_r2_keep_code: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel_valid[0] && sel_code[0] == 2'b00 &&
     !is_forcing(force_now[1:0])) |=> $stable(pins[0]));
endmodule

bind pwm_action_qual aq_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rld_mode  (rld_mode),
  .force_now (force_now),
  .sel_valid (sel_valid),
  .sel_code  (sel_code),
  .pins      (pins)
);

// File: tb/pwm_action_qual_tb.sv
`timescale 1ns/1ps
module pwm_action_qual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        out_a, out_b;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_action_qual dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ev_zero(ev_zero), .ev_period(ev_period),
    .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_a(out_a), .out_b(out_b)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mask bit 0 zero, 1 period, 2 compare A, 3 compare B
  task automatic pulse(input logic t, input logic [3:0] m);
    @(negedge clk);
    tick = t;
    {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero} = m;
    @(negedge clk);
    tick = 1'b0;
    {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero} = 4'b0;
  endtask

  // Action word from four packed 2-bit codes (zero, period, cmpA, cmpB).
  function automatic logic [15:0] word_of(input logic [7:0] c);
    return {6'b0, c[7:6], 2'b00, c[5:0]};
  endfunction

  // The last present event in ascending order decides.
  function automatic logic model(input logic [7:0] c, input logic [3:0] m, input logic cur);
    logic [1:0] code = 2'b00;
    for (int k = 0; k < 4; k++)
      if (m[k]) code = c[2*k +: 2];
    if (m == 4'b0) return cur;
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic clear_force();
    wr(2'd2, 16'h00C0);
    wr(2'd3, 16'h0000);
    pulse(1'b1, 4'b0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ea, eb;
    logic [7:0] cb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_a reset", out_a, 1'b0);
    chk("R1 out_b reset", out_b, 1'b0);
    pulse(1'b1, 4'b1111);
    chk("R1 out_a zero actions", out_a, 1'b0);
    chk("R1 out_b zero actions", out_b, 1'b0);

    // Sweep every code pattern against every event subset.
    ea = 1'b0; eb = 1'b0;
    for (int c = 0; c < 256; c++) begin
      cb = 8'(c) ^ 8'hA5;
      wr(2'd0, word_of(8'(c)));
      wr(2'd1, word_of(cb));
      for (int m = 0; m < 16; m++) begin
        pulse(1'b1, 4'(m));
        ea = model(8'(c), 4'(m), ea);
        eb = model(cb, 4'(m), eb);
        chk("R2 R3 R5 out_a", out_a, ea);
        chk("R2 R3 R5 out_b", out_b, eb);
      end
    end

    // R4: events without tick
    wr(2'd0, 16'h0333); wr(2'd1, 16'h0333);
    for (int m = 1; m < 16; m++) begin
      pulse(1'b0, 4'(m));
      chk("R4 out_a", out_a, ea);
      chk("R4 out_b", out_b, eb);
    end

    // Events drive A low and B high; force drives A high and B low.
    wr(2'd0, 16'h0005); wr(2'd1, 16'h000A);
    clear_force();
    chk("R6 base out_a", out_a, 1'b0);
    chk("R6 base out_b", out_b, 1'b1);
    wr(2'd3, 16'h0006);
    chk("R7 no move before tick a", out_a, 1'b0);
    chk("R7 no move before tick b", out_b, 1'b1);
    pulse(1'b1, 4'b0000);
    chk("R7 forced a", out_a, 1'b1);
    chk("R7 forced b", out_b, 1'b0);
    pulse(1'b1, 4'b0011);
    chk("R6 override a", out_a, 1'b1);
    chk("R6 override b", out_b, 1'b0);
    wr(2'd3, 16'h000F);
    pulse(1'b1, 4'b0001);
    chk("R6 code 11 a", out_a, 1'b0);
    chk("R6 code 11 b", out_b, 1'b1);

    // Shadow reload cases: {mode, non-load mask, load mask}
    for (int i = 0; i < 4; i++) begin
      logic [1:0] md;
      logic [3:0] nl, ld;
      case (i)
        0: begin md = 2'd0; nl = 4'b0010; ld = 4'b0001; end
        1: begin md = 2'd1; nl = 4'b0001; ld = 4'b0010; end
        2: begin md = 2'd2; nl = 4'b0100; ld = 4'b0001; end
        default: begin md = 2'd2; nl = 4'b0100; ld = 4'b0010; end
      endcase
      clear_force();
      wr(2'd2, {8'h00, md, 6'b0});
      wr(2'd3, 16'h0006);
      pulse(1'b1, nl);
      chk("R8 no load a", out_a, 1'b0);
      chk("R8 no load b", out_b, 1'b1);
      pulse(1'b1, ld);
      chk("R9 load tick a", out_a, 1'b0);
      chk("R9 load tick b", out_b, 1'b1);
      pulse(1'b1, 4'b0000);
      chk("R8 loaded a", out_a, 1'b1);
      chk("R8 loaded b", out_b, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule